// File: doc/BRIEF.md
# Piecewise-linear tanh activation with range-addressed correction

This block approximates the hyperbolic tangent of a signed fixed-point operand for use as a neuron activation. The operand is first registered. The block then folds it to a magnitude, with the most negative code saturated. A comparator picks one of two multiplier-free line segments, either y = x below 1.0 or y = 1 from 1.0 upward. In parallel, a range-addressed table returns one small error term for the interval of magnitudes that holds the operand. The term is subtracted from the segment value, the operand's sign is applied again, and the result is registered.

The word width `W` is a parameter. The input is two's complement with 3 integer bits and `W-4` fraction bits, so it covers [-8, 8). The output is two's complement with 1 integer bit and `W-2` fraction bits. Each table entry spans a contiguous run of magnitudes. The table bounds are held in units of 1/32. The correction values are held in units of 1/1024 and rounded to the output resolution when the block is elaborated. This keeps the subtrahend `W-4` bits wide instead of a full word.

Top module: `tanh_pwl_ralut`

## Requirements
- R1: While `rst` is high at a rising edge, and on the outputs after that edge, `out_valid` is 0 and `out_y` is 0.
- R2: `out_valid` repeats `in_valid` two rising edges later. `out_y` is the result for the `in_x` sampled two edges earlier, including for back-to-back operands.
- R3: With the default `W` = 9 (input Q3.5, output Q1.7), for every input code the output differs from tanh of the input value by at most 0.04.
- R4: For every input code except the most negative one, the output for -x is the exact two's-complement negation of the output for x.
- R5: The most negative input code (-8.0) gives the negation of the output for the largest positive code.
- R6: The output magnitude never exceeds 1.0, which is code 2^(W-2).
- R7: For input magnitudes below 0.3125, where a single table entry applies, the output equals the input value exactly. At the default width the output code is four times the input code, and zero maps to zero.
- R8: For input magnitudes of 3.5 and above, the output at the default width is exactly +1.0 or -1.0 (code 128 or -128).
- R9: The output is non-decreasing as the signed input code increases over the whole range, including across every table-entry boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand qualifier |
| in_x | input | W | Operand, two's complement Q3.(W-4) |
| out_valid | output | 1 | Result qualifier, two cycles behind `in_valid` |
| out_y | output | W | Result, two's complement Q1.(W-2) |

## Verification
Every one of the 512 input codes is applied one at a time. This sweep separates a wrong table value or a wrong bound (seen as an error above 0.04 or a drop in monotonicity) from a wrong sign fold (seen as broken odd symmetry or a bad result at the saturated code). A fixed list of hand-computed codes sits on both sides of each segment and table boundary, so the exact rounding of each correction is pinned down. A burst of operands with gaps in `in_valid` tells a correct two-stage alignment apart from an off-by-one stage. A reset asserted under live traffic shows that both stages clear.

// File: rtl/tanh_pwl_ralut.sv
module tanh_pwl_ralut #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_x,
  output logic         out_valid,
  output logic [W-1:0] out_y
);
  localparam int FI   = W - 4;
  localparam int FO   = W - 2;
  localparam int MW   = W - 1;
  localparam int CW   = FO - 2;
  localparam int NENT = 25;
  localparam int BSH  = FI - 5;
  localparam int QSH  = 10 - FO;
  localparam int QRND = (QSH > 0) ? (1 << (QSH - 1)) : 0;

  // range lower bounds in 1/32 units, corrections in 1/1024 units
  localparam int LO32 [NENT] = '{  0, 10, 14, 16, 18, 20, 22, 24, 26, 28, 30, 32, 34,
                                  36, 38, 40, 42, 44, 46, 48, 52, 56, 64, 80, 112};
  localparam int C1K  [NENT] = '{  0, 16, 29, 42, 58, 77, 99, 124, 152, 183, 217, 238, 213,
                                  190, 169, 151, 134, 120, 106, 89, 70, 50, 26, 8, 1};

  logic         v_a;
  logic [W-1:0] x_a;
  logic         neg, seg_lin;
  logic [MW-1:0] mag;
  logic [FO:0]  est, res;
  logic [CW-1:0] corr;
  logic [W-1:0] y_nxt;

  assign neg = x_a[W-1];
  assign mag = !neg ? x_a[MW-1:0] :
               (x_a[MW-1:0] == '0) ? {MW{1'b1}} : MW'(-x_a[MW-1:0]);

  assign seg_lin = mag < MW'(1 << FI);
  assign est     = seg_lin ? {1'b0, mag[FI-1:0], 2'b00} : {1'b1, {FO{1'b0}}};

  always_comb begin
    corr = '0;
    for (int i = 0; i < NENT; i++)
      if (int'(mag) >= (LO32[i] << BSH))
        corr = CW'((C1K[i] + QRND) >> QSH);
  end

  assign res   = est - {3'b000, corr};
  assign y_nxt = neg ? W'(-{1'b0, res}) : {1'b0, res};

  always_ff @(posedge clk) begin
    if (rst) begin
      v_a       <= 1'b0;
      x_a       <= '0;
      out_valid <= 1'b0;
      out_y     <= '0;
    end else begin
      v_a       <= in_valid;
      x_a       <= in_x;
      out_valid <= v_a;
      out_y     <= y_nxt;
    end
  end
endmodule

// File: rtl/tanh_pwl_ralut_chk.sv
module tanh_pwl_ralut_chk #(
  parameter int W = 9
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_x,
  input logic         out_valid,
  input logic [W-1:0] out_y
);
  localparam logic [W-1:0] ONE  = W'(1) << (W - 2);
  localparam logic [W-1:0] MINC = W'(1) << (W - 1);

  a_r2_valid_follow: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  a_r2_idle_follow: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);

  a_r4_sign_kept: assert property (@(posedge clk) disable iff (rst)
    (out_y != '0) |-> (out_y[W-1] == $past(in_x[W-1], 2)));

  a_r6_unit_range: assert property (@(posedge clk) disable iff (rst)
    out_y[W-1] ? (W'(-out_y) <= ONE) : (out_y <= ONE));

  a_r7_zero_in: assert property (@(posedge clk) disable iff (rst)
    ($past(in_x, 2) == '0) |-> (out_y == '0));

  a_r5_sat_negative: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) && $past(in_x, 2) == MINC) |-> out_y[W-1]);
endmodule

bind tanh_pwl_ralut tanh_pwl_ralut_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
  .out_valid(out_valid), .out_y(out_y)
);

// File: tb/tb_tanh_pwl_ralut.sv
`timescale 1ns/1ps
module tb_tanh_pwl_ralut;
  localparam int W = 9;
  localparam int NV = 15;
  // {input code, expected output code}
  localparam logic [17:0] VEC [NV] = '{
    {9'd0,   9'd0},   {9'd1,   9'd4},   {9'd9,   9'd36},  {9'd10,  9'd38},
    {9'd16,  9'd59},  {9'd31,  9'd97},  {9'd32,  9'd98},  {9'd64,  9'd125},
    {9'd80,  9'd127}, {9'd112, 9'd128}, {9'd255, 9'd128}, {9'd496, 9'd453},
    {9'd480, 9'd414}, {9'd256, 9'd384}, {9'd511, 9'd508}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] in_x = '0;
  logic out_valid;
  logic [W-1:0] out_y;
  int n_tests = 0;
  int n_fail = 0;
  logic [W-1:0] res [512];

  always #4 clk = ~clk;

  tanh_pwl_ralut #(.W(W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .out_valid(out_valid), .out_y(out_y));

  function automatic int sv(input logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, output logic [W-1:0] y, output logic v);
    @(negedge clk); in_valid = 1'b1; in_x = x;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk); y = out_y; v = out_valid;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] y;
    logic v;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    chk(out_y == '0, "R1 data in reset", sv(out_y), 0);
    rst = 1'b0;

    // vector table: exact codes at segment and range boundaries
    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][17:9], y, v);
      chk(y == VEC[k][8:0], "R7/R8/R5 vector", sv(y), sv(VEC[k][8:0]));
      chk(v == 1'b1, "R2 valid after two edges", int'(v), 1);
    end

    // full sweep
    for (int c = 0; c < 512; c++) begin
      apply(W'(c), y, v);
      res[c] = y;
    end
    for (int c = 0; c < 512; c++) begin
      real xr, yr, e;
      int mag;
      xr = real'(sv(W'(c))) / 32.0;
      yr = real'(sv(res[c])) / 128.0;
      e = yr - $tanh(xr);
      if (e < 0.0) e = -e;
      chk(e <= 0.04, "R3 accuracy", sv(res[c]), int'($tanh(xr) * 128.0));
      mag = sv(res[c]) < 0 ? -sv(res[c]) : sv(res[c]);
      chk(mag <= 128, "R6 range", mag, 128);
      mag = sv(W'(c)) < 0 ? -sv(W'(c)) : sv(W'(c));
      if (mag < 10) chk(sv(res[c]) == 4 * sv(W'(c)), "R7 identity", sv(res[c]), 4 * sv(W'(c)));
      if (mag >= 112) chk(sv(res[c]) == (sv(W'(c)) < 0 ? -128 : 128), "R8 unity", sv(res[c]),
                          sv(W'(c)) < 0 ? -128 : 128);
    end
    for (int c = 1; c < 256; c++)
      chk(sv(res[512 - c]) == -sv(res[c]), "R4 odd symmetry", sv(res[512 - c]), -sv(res[c]));
    chk(sv(res[256]) == -sv(res[255]), "R5 saturation", sv(res[256]), -sv(res[255]));
    for (int s = -256; s < 255; s++)
      chk(sv(res[W'(s + 1)]) >= sv(res[W'(s)]), "R9 monotone", sv(res[W'(s + 1)]), sv(res[W'(s)]));

    // back-to-back burst with gaps
    begin
      bit pat [6] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
      logic [W-1:0] xs [6] = '{9'd16, 9'd32, 9'd496, 9'd1, 9'd256, 9'd64};
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (k >= 2) begin
          chk(out_valid == pat[k-2], "R2 burst valid", int'(out_valid), int'(pat[k-2]));
          chk(out_y == res[xs[k-2]], "R2 burst data", sv(out_y), sv(res[xs[k-2]]));
        end
        if (k < 6) begin in_valid = pat[k]; in_x = xs[k]; end
        else begin in_valid = 1'b0; in_x = '0; end
      end
    end

    // reset under traffic
    @(negedge clk); in_valid = 1'b1; in_x = 9'd80;
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
    chk(out_y == '0, "R1 data after reset", sv(out_y), 0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 first cycle out of reset", int'(out_valid), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule